// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block provides message signalling between the two ports of a shared two-port memory. It watches the access strobes of both ports and reserves the top two addresses of the array as mailboxes. The topmost address belongs to the right port and the one just below it belongs to the left port. The ordinary memory array holds the mailbox contents. This block only decodes the addresses and keeps one interrupt flag for each port.

When one port writes into the other port's mailbox, the mailbox owner's interrupt goes active. The owner clears it by reading its own mailbox. Reading the other side's mailbox has no effect on either flag. Each port has a collision busy flag. While that flag is active, the port can neither set the other port's interrupt nor clear its own.

Strobes are sampled on each rising clock edge. Each interrupt output is active-low and comes straight from a register, so it changes on the edge that samples the access.

Top module: `mbx_irq`

## Requirements
- R1: With `rst` high at a clock edge, both `lft_irq_n` and `rgt_irq_n` are 1 (inactive) after that edge.
- R2: A sampled right-port write (`rgt_en`=1, `rgt_wr`=1, `rgt_busy`=0) to address 2^AW-2 drives `lft_irq_n` to 0 after that edge.
- R3: A sampled left-port write (`lft_en`=1, `lft_wr`=1, `lft_busy`=0) to address 2^AW-1 drives `rgt_irq_n` to 0 after that edge.
- R4: A port's read (`en`=1, `wr`=0, busy=0) of its own mailbox returns its interrupt output to 1 after that edge. The left port's mailbox is 2^AW-2 and the right port's is 2^AW-1.
- R5: A port's read of the opposite port's mailbox changes neither interrupt output.
- R6: A write into the opposite mailbox made while the writing port's busy input is 1 does not activate the interrupt.
- R7: A read of the port's own mailbox made while that port's busy input is 1 does not clear its interrupt.
- R8: When the same flag is set and cleared in the same cycle, the set wins and the interrupt output is 0 after that edge.
- R9: Accesses with `en`=0, accesses to any other address, and a port's write to its own mailbox leave both interrupt outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lft_en | input | 1 | Left port access strobe |
| lft_wr | input | 1 | Left port write (1) or read (0) |
| lft_addr | input | AW | Left port address |
| lft_busy | input | 1 | Left port collision busy, active high |
| rgt_en | input | 1 | Right port access strobe |
| rgt_wr | input | 1 | Right port write (1) or read (0) |
| rgt_addr | input | AW | Right port address |
| rgt_busy | input | 1 | Right port collision busy, active high |
| lft_irq_n | output | 1 | Left port interrupt, active low |
| rgt_irq_n | output | 1 | Right port interrupt, active low |

## Verification
The bench builds the block with AW=4, which puts the mailboxes at 0xF (right) and 0xE (left). With addresses this narrow, the near misses are cheap to hit. The bench drives 0x7, which differs from a mailbox only in the top bit, and 0xD, the address just below both mailboxes. This shows that the match uses every address bit. Same-cycle set/clear collisions, busy on either side, and writes to a port's own mailbox all fit into one short vector table.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic {SIDE_L = 1'b0, SIDE_R = 1'b1} side_e;

  // Mailbox location of the given side for an address width aw.
  function automatic int unsigned mbox_loc(int unsigned aw, side_e side);
    int unsigned top;
    top = (32'd1 << aw) - 32'd1;
    return (side == SIDE_L) ? top - 32'd1 : top;
  endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_pkg::*;
#(
  parameter int AW = 12,
  parameter side_e SIDE = SIDE_L
) (
  input  logic          en,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic          busy,
  output logic          own_clr,
  output logic          peer_set
);
  localparam logic [AW-1:0] OWN_LOC  = AW'(mbox_loc(AW, SIDE));
  localparam logic [AW-1:0] PEER_LOC =
    AW'(mbox_loc(AW, (SIDE == SIDE_L) ? SIDE_R : SIDE_L));

  logic live;
  assign live     = en & ~busy;
  assign own_clr  = live & ~wr & (addr == OWN_LOC);
  assign peer_set = live &  wr & (addr == PEER_LOC);
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic irq_n
);
  always_ff @(posedge clk) begin
    if (rst)       irq_n <= 1'b1;
    else if (set)  irq_n <= 1'b0;
    else if (clr)  irq_n <= 1'b1;
  end

  // R8: a set always lands, even against a clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    set |=> !irq_n);
  // R4: a lone clear releases the interrupt
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> irq_n);
  // R9: no event, no change
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!set && !clr) |=> $stable(irq_n));
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq
  import mbx_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lft_en,
  input  logic          lft_wr,
  input  logic [AW-1:0] lft_addr,
  input  logic          lft_busy,
  input  logic          rgt_en,
  input  logic          rgt_wr,
  input  logic [AW-1:0] rgt_addr,
  input  logic          rgt_busy,
  output logic          lft_irq_n,
  output logic          rgt_irq_n
);
  localparam int NP = 2;
  localparam logic [AW-1:0] L_LOC = AW'(mbox_loc(AW, SIDE_L));
  localparam logic [AW-1:0] R_LOC = AW'(mbox_loc(AW, SIDE_R));

  logic          en_v   [NP];
  logic          wr_v   [NP];
  logic [AW-1:0] addr_v [NP];
  logic          busy_v [NP];
  logic          clr_v  [NP];
  logic          set_v  [NP];
  logic          irq_v  [NP];

  assign en_v[0] = lft_en;  assign wr_v[0] = lft_wr;
  assign addr_v[0] = lft_addr;  assign busy_v[0] = lft_busy;
  assign en_v[1] = rgt_en;  assign wr_v[1] = rgt_wr;
  assign addr_v[1] = rgt_addr;  assign busy_v[1] = rgt_busy;

  for (genvar p = 0; p < NP; p++) begin : g_port
    mbx_port_decode #(
      .AW   (AW),
      .SIDE ((p == 0) ? SIDE_L : SIDE_R)
    ) u_dec (
      .en       (en_v[p]),
      .wr       (wr_v[p]),
      .addr     (addr_v[p]),
      .busy     (busy_v[p]),
      .own_clr  (clr_v[p]),
      .peer_set (set_v[p])
    );
    // the flag of port p is set by the opposite port's decoder
    mbx_flag u_flag (
      .clk   (clk),
      .rst   (rst),
      .set   (set_v[NP-1-p]),
      .clr   (clr_v[p]),
      .irq_n (irq_v[p])
    );
  end

  assign lft_irq_n = irq_v[0];
  assign rgt_irq_n = irq_v[1];

  // R1
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (lft_irq_n && rgt_irq_n));
  // R2
  p_rgt_write_sets_r2: assert property (@(posedge clk) disable iff (rst)
    (rgt_en && rgt_wr && !rgt_busy && rgt_addr == L_LOC) |=> !lft_irq_n);
  // R3
  p_lft_write_sets_r3: assert property (@(posedge clk) disable iff (rst)
    (lft_en && lft_wr && !lft_busy && lft_addr == R_LOC) |=> !rgt_irq_n);
  // R5: left peeking at the right mailbox cannot release the right flag
  p_peer_read_r5: assert property (@(posedge clk) disable iff (rst)
    (lft_en && !lft_wr && lft_addr == R_LOC &&
     !(rgt_en && !rgt_wr && rgt_addr == R_LOC)) |=> !$rose(rgt_irq_n));
  // R6
  p_busy_no_set_r6: assert property (@(posedge clk) disable iff (rst)
    (rgt_en && rgt_wr && rgt_busy && rgt_addr == L_LOC) |=> !$fell(lft_irq_n));
  // R7
  p_busy_no_clr_r7: assert property (@(posedge clk) disable iff (rst)
    (lft_en && !lft_wr && lft_busy && lft_addr == L_LOC) |=> !$rose(lft_irq_n));
endmodule

// File: tb/mbx_irq_tb.sv
module mbx_irq_tb;
  localparam int AW = 4;
  localparam int NV = 17;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lft_en = 0, lft_wr = 0, lft_busy = 0;
  logic rgt_en = 0, rgt_wr = 0, rgt_busy = 0;
  logic [AW-1:0] lft_addr = '0, rgt_addr = '0;
  logic lft_irq_n, rgt_irq_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mbx_irq #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst),
    .lft_en(lft_en), .lft_wr(lft_wr), .lft_addr(lft_addr), .lft_busy(lft_busy),
    .rgt_en(rgt_en), .rgt_wr(rgt_wr), .rgt_addr(rgt_addr), .rgt_busy(rgt_busy),
    .lft_irq_n(lft_irq_n), .rgt_irq_n(rgt_irq_n)
  );

  // {le, lw, la[3:0], lb, re, rw, ra[3:0], rb, exp_lft_n, exp_rgt_n}
  // left mailbox 0xE, right mailbox 0xF
  localparam logic [15:0] VEC [NV] = '{
    {1'b0,1'b0,4'h0,1'b0, 1'b0,1'b0,4'h0,1'b0, 2'b11}, // idle, R9
    {1'b0,1'b0,4'h0,1'b0, 1'b1,1'b1,4'hE,1'b0, 2'b01}, // R2
    {1'b0,1'b0,4'h0,1'b0, 1'b1,1'b0,4'hE,1'b0, 2'b01}, // R5 right peeks left box
    {1'b1,1'b0,4'hF,1'b0, 1'b0,1'b0,4'h0,1'b0, 2'b01}, // R5 left peeks right box
    {1'b1,1'b0,4'hE,1'b1, 1'b0,1'b0,4'h0,1'b0, 2'b01}, // R7 busy read
    {1'b1,1'b0,4'hE,1'b0, 1'b0,1'b0,4'h0,1'b0, 2'b11}, // R4 left clears
    {1'b1,1'b1,4'hF,1'b1, 1'b0,1'b0,4'h0,1'b0, 2'b11}, // R6 busy write
    {1'b1,1'b1,4'hF,1'b0, 1'b0,1'b0,4'h0,1'b0, 2'b10}, // R3
    {1'b1,1'b1,4'hE,1'b0, 1'b0,1'b0,4'h0,1'b0, 2'b10}, // R9 own-box write
    {1'b0,1'b0,4'h0,1'b0, 1'b1,1'b1,4'h7,1'b0, 2'b10}, // R9 near-miss address
    {1'b0,1'b0,4'h0,1'b0, 1'b0,1'b1,4'hE,1'b0, 2'b10}, // R9 strobe low
    {1'b0,1'b0,4'h0,1'b0, 1'b1,1'b0,4'hF,1'b1, 2'b10}, // R7 right busy read
    {1'b0,1'b0,4'h0,1'b0, 1'b1,1'b0,4'hF,1'b0, 2'b11}, // R4 right clears
    {1'b1,1'b0,4'hE,1'b0, 1'b1,1'b1,4'hE,1'b0, 2'b01}, // R8 left flag
    {1'b1,1'b1,4'hF,1'b0, 1'b1,1'b0,4'hF,1'b0, 2'b00}, // R8 right flag
    {1'b1,1'b0,4'hE,1'b0, 1'b1,1'b1,4'hE,1'b1, 2'b10}, // R6 + R4 set blocked
    {1'b1,1'b1,4'hD,1'b0, 1'b1,1'b0,4'hD,1'b0, 2'b10}  // R9 address below boxes
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 lft", lft_irq_n, 1'b1);
    check("R1 rgt", rgt_irq_n, 1'b1);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      {lft_en, lft_wr, lft_addr, lft_busy} = VEC[i][15:9];
      {rgt_en, rgt_wr, rgt_addr, rgt_busy} = VEC[i][8:2];
      @(negedge clk);
      check($sformatf("vec%0d lft", i), lft_irq_n, VEC[i][1]);
      check($sformatf("vec%0d rgt", i), rgt_irq_n, VEC[i][0]);
    end
    // R2/R3 both flags raised together, then R1 reset from active state
    lft_en = 1; lft_wr = 1; lft_addr = 4'hF; lft_busy = 0;
    rgt_en = 1; rgt_wr = 1; rgt_addr = 4'hE; rgt_busy = 0;
    @(negedge clk);
    check("R2 both", lft_irq_n, 1'b0);
    check("R3 both", rgt_irq_n, 1'b0);
    lft_en = 0; rgt_en = 0;
    rst = 1;
    @(negedge clk);
    check("R1 mid lft", lft_irq_n, 1'b1);
    check("R1 mid rgt", rgt_irq_n, 1'b1);
    // R1: reset overrides a simultaneous set
    rgt_en = 1; rgt_wr = 1; rgt_addr = 4'hE;
    @(negedge clk);
    check("R1 over set", lft_irq_n, 1'b1);
    rst = 0; rgt_en = 0;
    @(negedge clk);
    check("R9 idle after reset", lft_irq_n, 1'b1);
    finish_run();
  end
endmodule